// File: doc/BRIEF.md
# Hit-Ahead Hierarchical Priority Encoder

The block takes a wide match vector, such as the per-entry match lines of a ternary lookup array. It returns the index of the lowest-numbered asserted bit and a global hit flag. The vector is cut into equal blocks. Inside each block, a running "no hit so far" product marks the first asserted bit. That one-hot mark yields a local hit and a local index.

A second copy of the same product runs across the block hit signals. It picks the lowest block that has a hit, as a one-hot select. An AND-OR multiplexer uses that select to choose the local index of the chosen block. The block number forms the upper address field and the local index forms the lower field.

The encoding logic is purely combinational. A generate-time parameter adds an output register, and the default build has it. With the defaults (64 inputs, blocks of 8), the address is 6 bits wide: a 3-bit block number above a 3-bit local index.

Top module: `hit_ahead_penc`

## Requirements
- R1: When any bit of `match_i` is set, `hit_o` is 1 and `addr_o` equals the index of the lowest-numbered set bit.
- R2: When no bit of `match_i` is set, `hit_o`, `addr_o` and `blk_sel_o` are all zero.
- R3: `addr_o[5:3]` holds the block number (bit index divided by 8) and `addr_o[2:0]` holds the position inside that block (bit index modulo 8).
- R4: `blk_sel_o` is one-hot whenever `hit_o` is 1. Bit b is set exactly when block b (bits 8b to 8b+7) has a set bit and every lower block has none.
- R5: Set bits above the lowest set bit have no effect on `addr_o` or `blk_sel_o`; lower index always wins.
- R6: With the default registered output, a value on `match_i` present at a rising clock edge appears on the outputs right after that edge and holds until the next edge.
- R7: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| match_i | input | 64 | Match vector, bit 0 highest priority |
| hit_o | output | 1 | Any bit of the vector set |
| addr_o | output | 6 | Index of the lowest set bit, {block, local} |
| blk_sel_o | output | 8 | One-hot select of the winning block |

## Verification
On every cycle, the assertions check that the internal block select is one-hot and agrees with the block hits. They also check that the registered outputs agree with each other: a miss gives zero outputs, a hit gives exactly one select bit, and that bit matches the upper address field. Whether the address names the lowest set bit, and whether higher bits are really ignored, can only be shown by the bench. It compares each result against a linear scan over single bits, block-edge patterns, dense and sparse random vectors, and vectors whose upper bits vary while the lowest bit stays fixed.

// File: rtl/hit_ahead_penc_pkg.sv
package hit_ahead_penc_pkg;
  localparam int unsigned DEF_WIDTH = 64;
  localparam int unsigned DEF_BLK   = 8;
endpackage

// File: rtl/hit_chain.sv
// Prefix "nothing ahead" chain: h[i+1] = h[i] & ~req[i]; first = req & h
module hit_chain #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] first_o,
  output logic         any_o
);
  logic [N:0] nh;

  always_comb begin
    nh[0] = 1'b1;
    for (int i = 0; i < N; i++) begin
      nh[i+1]    = nh[i] & ~req_i[i];
      first_o[i] = req_i[i] & nh[i];
    end
    any_o = ~nh[N];
  end

  always_comb begin
    if (!$isunknown(req_i)) begin
      p_first_onehot_r4: assert ($onehot0(first_o) && ((first_o != '0) == (req_i != '0)));
    end
  end
endmodule

// File: rtl/blk_encoder.sv
module blk_encoder #(
  parameter int unsigned BLK = 8,
  localparam int unsigned LW = (BLK > 1) ? $clog2(BLK) : 1
) (
  input  logic [BLK-1:0] bits_i,
  output logic           hit_o,
  output logic [LW-1:0]  idx_o
);
  logic [BLK-1:0] first;

  hit_chain #(.N(BLK)) u_chain (
    .req_i  (bits_i),
    .first_o(first),
    .any_o  (hit_o)
  );

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < BLK; i++) begin
      if (first[i]) idx_o = idx_o | LW'(i);
    end
  end
endmodule

// File: rtl/addr_mux.sv
// AND-OR select of the winning block's local index, joined with block number
module addr_mux #(
  parameter int unsigned NBLK = 8,
  parameter int unsigned LW   = 3,
  localparam int unsigned BW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic [NBLK-1:0]         sel_i,
  input  logic [NBLK-1:0][LW-1:0] loc_i,
  output logic [BW+LW-1:0]        addr_o
);
  logic [BW-1:0] blk_num;
  logic [LW-1:0] loc_sel;

  always_comb begin
    blk_num = '0;
    loc_sel = '0;
    for (int b = 0; b < NBLK; b++) begin
      if (sel_i[b]) begin
        blk_num = blk_num | BW'(b);
        loc_sel = loc_sel | loc_i[b];
      end
    end
    addr_o = {blk_num, loc_sel};
  end
endmodule

// File: rtl/hit_ahead_penc.sv
module hit_ahead_penc
  import hit_ahead_penc_pkg::*;
#(
  parameter int unsigned WIDTH   = DEF_WIDTH,
  parameter int unsigned BLK     = DEF_BLK,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned NBLK = WIDTH / BLK,
  localparam int unsigned LW   = (BLK > 1) ? $clog2(BLK) : 1,
  localparam int unsigned BW   = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int unsigned AW   = BW + LW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] match_i,
  output logic             hit_o,
  output logic [AW-1:0]    addr_o,
  output logic [NBLK-1:0]  blk_sel_o
);
  logic [NBLK-1:0]         blk_hit;
  logic [NBLK-1:0][LW-1:0] blk_idx;
  logic [NBLK-1:0]         sel_c;
  logic                    hit_c;
  logic [AW-1:0]           addr_c;

  // level 1: per-block chains
  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    blk_encoder #(.BLK(BLK)) u_blk (
      .bits_i(match_i[b*BLK +: BLK]),
      .hit_o (blk_hit[b]),
      .idx_o (blk_idx[b])
    );
  end

  // level 2: chain across block hits
  hit_chain #(.N(NBLK)) u_grp (
    .req_i  (blk_hit),
    .first_o(sel_c),
    .any_o  (hit_c)
  );

  addr_mux #(.NBLK(NBLK), .LW(LW)) u_mux (
    .sel_i (sel_c),
    .loc_i (blk_idx),
    .addr_o(addr_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_o     <= 1'b0;
        addr_o    <= '0;
        blk_sel_o <= '0;
      end else begin
        hit_o     <= hit_c;
        addr_o    <= addr_c;
        blk_sel_o <= sel_c;
      end
    end
  end else begin : g_comb
    assign hit_o     = hit_c;
    assign addr_o    = addr_c;
    assign blk_sel_o = sel_c;
  end

  p_sel_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_c |-> ($countones(sel_c) == 1) && ((sel_c & blk_hit) == sel_c));
  p_nohit_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_c |-> (blk_hit == '0) && (sel_c == '0));
  p_out_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (addr_o == '0) && (blk_sel_o == '0));
  p_out_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ($countones(blk_sel_o) == 1) && blk_sel_o[addr_o[AW-1:LW]]);
  p_loc_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_c |-> match_i[addr_c]);
endmodule

// File: tb/hit_ahead_penc_tb.sv
module hit_ahead_penc_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] match_i = '0;
  logic        hit_o;
  logic [5:0]  addr_o;
  logic [7:0]  blk_sel_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  hit_ahead_penc u_dut (
    .clk_i, .rst_ni, .match_i, .hit_o, .addr_o, .blk_sel_o
  );

  function automatic int lowest(logic [63:0] v);
    for (int i = 0; i < 64; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R1 R2 R3 R4 R6: drive before edge, sample at following negedge
  task automatic apply(logic [63:0] v, string req);
    int e;
    @(negedge clk_i);
    match_i = v;
    @(negedge clk_i);
    e = lowest(v);
    if (e < 0) begin
      chk({req, "/R2 hit"}, 64'(hit_o), 64'd0);
      chk({req, "/R2 addr"}, 64'(addr_o), 64'd0);
      chk({req, "/R2 sel"}, 64'(blk_sel_o), 64'd0);
    end else begin
      chk({req, "/R1 hit"}, 64'(hit_o), 64'd1);
      chk({req, "/R3 addr"}, 64'(addr_o), 64'(e));
      chk({req, "/R4 sel"}, 64'(blk_sel_o), 64'(8'd1 << (e / 8)));
    end
  endtask

  initial begin
    #100000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    int p;
    void'($urandom(32'h1d5a));
    match_i = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk_i);
    // R7: reset holds outputs low despite active input
    chk("R7 hit", 64'(hit_o), 64'd0);
    chk("R7 addr", 64'(addr_o), 64'd0);
    chk("R7 sel", 64'(blk_sel_o), 64'd0);
    rst_ni = 1'b1;

    apply(64'd0, "zero");
    apply(64'hFFFF_FFFF_FFFF_FFFF, "all");
    apply(64'h8000_0000_0000_0000, "top");
    for (int i = 0; i < 64; i++) apply(64'd1 << i, "single");
    for (int b = 1; b < 8; b++) apply((64'd1 << (8*b)) | (64'd1 << (8*b - 1)), "edge");

    // R6: output holds the value sampled at the last edge
    @(negedge clk_i); match_i = 64'h10;
    @(negedge clk_i);
    match_i = 64'h1;
    #1 chk("R6 hold", 64'(addr_o), 64'd4);
    @(negedge clk_i);
    chk("R6 next", 64'(addr_o), 64'd0);

    // R5: upper bits vary, lowest fixed
    for (int k = 0; k < 200; k++) begin
      p = $urandom_range(63);
      v = {$urandom(), $urandom()};
      v = (v & ~((64'd1 << p) - 64'd1) & ~(64'd1 << p)) | (64'd1 << p);
      @(negedge clk_i); match_i = v;
      @(negedge clk_i);
      chk("R5 addr", 64'(addr_o), 64'(p));
      chk("R5 sel", 64'(blk_sel_o), 64'(8'd1 << (p / 8)));
    end

    for (int k = 0; k < 1500; k++) begin
      v = {$urandom(), $urandom()};
      case (k % 3)
        0: v = v & {$urandom(), $urandom()} & {$urandom(), $urandom()};
        1: v = v & ~((64'd1 << $urandom_range(63)) - 64'd1);
        default: ;
      endcase
      apply(v, "rand");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule